// File: doc/BRIEF.md
# Serial CRC-8 Frame Checker

This block folds a serial bit stream into an 8-bit cyclic redundancy remainder, one bit per accepted clock cycle. The generator is x^8 + x^5 + x^4 + 1, used in its bit-reversed form so that bits can be taken least significant first. Each byte therefore enters starting at bit 0, and bytes enter in the order they are sent. The remainder starts from zero.

A frame ends with its own check byte, which is shifted in exactly like the data. When the frame arrived intact, the remainder is zero once that byte has been consumed. A zero flag reports this directly. A saturating bit counter shows how many bits have been consumed since the last clear, so the caller can confirm that a frame of 64 bits (seven data bytes plus the check byte) or of 72 bits (eight data bytes plus the check byte) was taken completely. A clear strobe starts each new frame.

Top module: `serial_crc8_checker`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the remainder is 0x00, the bit count is 0, and the zero flag is 1.
- R2: A `clr` pulse sets the remainder and the bit count to 0 on the next edge. `clr` takes priority over `bit_vld` in the same cycle, so the bit offered in that cycle is dropped.
- R3: In a cycle where `bit_vld` and `clr` are both low, the remainder and the bit count keep their values, whatever `bit_in` is.
- R4: For each accepted bit, let f = remainder[0] XOR `bit_in`. The next remainder is (remainder >> 1) XOR 0x8C when f is 1, and remainder >> 1 when f is 0. As a result, the new bit 7 equals f.
- R5: Bits enter least significant first. Starting from 0x00, the byte 0xB4 leaves the remainder at 0x53. Shifting in 0x53 after that returns the remainder to 0x00.
- R6: The zero flag is 1 exactly when the current remainder is 0x00.
- R7: A frame of 7 or 8 data bytes followed by its check byte (the remainder of those data bytes) leaves the remainder at 0x00 and the flag at 1.
- R8: Inverting any single bit of a 64-bit frame leaves a nonzero remainder and the flag at 0.
- R9: The 7-bit bit count rises by one per accepted bit and stops at 127 instead of wrapping. It reads 64 or 72 after a complete frame of that size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Starts a new frame; clears the remainder and the count |
| bit_vld | input | 1 | Marks `bit_in` as a bit to consume this cycle |
| bit_in | input | 1 | Serial data bit, least significant bit of each byte first |
| crc_o | output | 8 | Current remainder |
| bit_cnt_o | output | 7 | Bits consumed since the last clear, saturating |
| crc_zero_o | output | 1 | High when the remainder is zero |

## Verification
The bench checks the known pair 0xB4 then 0x53 to catch a design that shifts the wrong way or places its taps badly; such a design would not land on 0x53. It sends random frames of both lengths, compares the remainder after every bit against a model, and inverts each bit position of a frame in turn to show that no single error slips through as zero. It also drives `clr` together with `bit_vld` to catch a design that gives the bit priority, which would leave a count of 1. It toggles `bit_in` while `bit_vld` is low to catch a remainder that moves without a strobe, and drives more than 127 bits to catch a counter that wraps back to small values.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
    parameter int unsigned CRC_W     = 8;
    parameter logic [7:0]  POLY_REFL = 8'h8C;
    parameter int unsigned CNT_W     = 7;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CNT_W-1:0] cnt;
    } chk_state_t;
endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
    parameter int unsigned W         = 8,
    parameter logic [W-1:0] POLY_REFL = 8'h8C
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb = crc_i[0] ^ bit_i;

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W - 1) begin : g_top
            assign crc_o[i] = POLY_REFL[i] & fb;
        end else if (POLY_REFL[i]) begin : g_tap
            assign crc_o[i] = crc_i[i+1] ^ fb;
        end else begin : g_pass
            assign crc_o[i] = crc_i[i+1];
        end
    end
endmodule

// File: rtl/sat_count_step.sv
module sat_count_step #(
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] cnt_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_comb begin
        cnt_o = cnt_i;
        if (inc_i && (cnt_i != CNT_MAX)) begin
            cnt_o = cnt_i + 1'b1;
        end
    end
endmodule

// File: rtl/serial_crc8_checker.sv
module serial_crc8_checker
    import crc8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic             crc_zero_o
);
    chk_state_t state_d, state_q;
    logic [CRC_W-1:0] crc_step;
    logic [CNT_W-1:0] cnt_step;

    crc_bit_step #(
        .W         (CRC_W),
        .POLY_REFL (POLY_REFL[CRC_W-1:0])
    ) u_step (
        .crc_i (state_q.crc),
        .bit_i (bit_in),
        .crc_o (crc_step)
    );

    sat_count_step #(
        .W (CNT_W)
    ) u_cnt (
        .cnt_i (state_q.cnt),
        .inc_i (1'b1),
        .cnt_o (cnt_step)
    );

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = '0;
        end else if (bit_vld) begin
            state_d.crc = crc_step;
            state_d.cnt = cnt_step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign crc_o      = state_q.crc;
    assign bit_cnt_o  = state_q.cnt;
    assign crc_zero_o = (state_q.crc == '0);
endmodule

// File: rtl/crc8_check_sva.sv
module crc8_check_sva #(
    parameter int unsigned CRC_W = 8,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             bit_vld,
    input logic             bit_in,
    input logic [CRC_W-1:0] crc_o,
    input logic [CNT_W-1:0] bit_cnt_o,
    input logic             crc_zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_o == '0) && (bit_cnt_o == '0) && crc_zero_o); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !bit_vld) |=> $stable(crc_o) && $stable(bit_cnt_o)); // R3

    AST_FEEDBACK_MSB: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !clr) |=> crc_o[CRC_W-1] == ($past(crc_o[0]) ^ $past(bit_in))); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !clr && bit_cnt_o != CNT_MAX) |=> bit_cnt_o == $past(bit_cnt_o) + 1'b1); // R9

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !clr && bit_cnt_o == CNT_MAX) |=> bit_cnt_o == CNT_MAX); // R9
endmodule

bind serial_crc8_checker crc8_check_sva #(
    .CRC_W (crc8_pkg::CRC_W),
    .CNT_W (crc8_pkg::CNT_W)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .crc_o      (crc_o),
    .bit_cnt_o  (bit_cnt_o),
    .crc_zero_o (crc_zero_o)
);

// File: tb/test_serial_crc8_checker.sv
module test_serial_crc8_checker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] crc_o;
    logic [6:0] bit_cnt_o;
    logic       crc_zero_o;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    serial_crc8_checker i_serial_crc8_checker (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .crc_o      (crc_o),
        .bit_cnt_o  (bit_cnt_o),
        .crc_zero_o (crc_zero_o)
    );

    function automatic logic [7:0] ref_step(logic [7:0] c, logic b);
        logic [7:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ 8'h8C;
        return r;
    endfunction

    function automatic logic [7:0] ref_byte(logic [7:0] c, logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) r = ref_step(r, d[i]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(crc_o == 8'h00, "R1 crc", crc_o, 0);
        chk(bit_cnt_o == 7'd0, "R1 cnt", bit_cnt_o, 0);
        chk(crc_zero_o == 1'b1, "R1 flag", crc_zero_o, 1);
        rst = 1'b0;
    endtask

    task automatic t_known_pair();
        logic [7:0] a = 8'hB4;
        logic [7:0] b = 8'h53;
        pulse_clr();
        for (int i = 0; i < 8; i++) send_bit(a[i]);
        chk(crc_o == 8'h53, "R5 0xB4 remainder", crc_o, 8'h53);
        chk(crc_zero_o == 1'b0, "R6 flag low on nonzero", crc_zero_o, 0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        chk(crc_o == 8'h00, "R5 back to zero", crc_o, 0);
        chk(crc_zero_o == 1'b1, "R6 flag high on zero", crc_zero_o, 1);
        chk(bit_cnt_o == 7'd16, "R9 count 16", bit_cnt_o, 16);
    endtask

    task automatic t_clear_priority();
        send_bit(1'b1);
        send_bit(1'b0);
        @(negedge clk);
        clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        clr = 1'b0; bit_vld = 1'b0;
        chk(crc_o == 8'h00, "R2 crc after clr+vld", crc_o, 0);
        chk(bit_cnt_o == 7'd0, "R2 cnt after clr+vld", bit_cnt_o, 0);
    endtask

    task automatic t_hold();
        logic [7:0] snap_c;
        logic [6:0] snap_n;
        pulse_clr();
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        snap_c = crc_o;
        snap_n = bit_cnt_o;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_in = i[0];
        end
        chk(crc_o == snap_c && snap_c != 0, "R3 crc holds", crc_o, snap_c);
        chk(bit_cnt_o == snap_n, "R3 cnt holds", bit_cnt_o, snap_n);
    endtask

    task automatic t_frame(input int nbytes, input int flip_pos);
        logic [7:0] data [0:8];
        logic [7:0] model = 8'h00;
        int         bad = 0;
        logic [7:0] first_bad_act = 0;
        logic [7:0] first_bad_exp = 0;
        for (int k = 0; k < nbytes; k++) begin
            data[k] = 8'($urandom);
            model = ref_byte(model, data[k]);
        end
        data[nbytes] = model;
        pulse_clr();
        model = 8'h00;
        for (int k = 0; k <= nbytes; k++) begin
            for (int i = 0; i < 8; i++) begin
                logic b;
                b = data[k][i] ^ ((k * 8 + i) == flip_pos);
                send_bit(b);
                model = ref_step(model, b);
                if (crc_o != model && bad == 0) begin
                    first_bad_act = crc_o;
                    first_bad_exp = model;
                end
                if (crc_o != model) bad++;
            end
        end
        chk(bad == 0, "R4 per-bit remainder", first_bad_act, first_bad_exp);
        if (flip_pos < 0) begin
            chk(crc_o == 8'h00, "R7 residue zero", crc_o, 0);
            chk(crc_zero_o == 1'b1, "R7 flag high", crc_zero_o, 1);
            chk(bit_cnt_o == 7'((nbytes + 1) * 8), "R9 frame count", bit_cnt_o, (nbytes + 1) * 8);
        end else begin
            chk(crc_o != 8'h00 && crc_zero_o == 1'b0, "R8 flip detected", crc_o, 1);
        end
    endtask

    task automatic t_saturate();
        pulse_clr();
        for (int i = 0; i < 127; i++) send_bit(i[1]);
        chk(bit_cnt_o == 7'd127, "R9 reaches max", bit_cnt_o, 127);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        chk(bit_cnt_o == 7'd127, "R9 saturated", bit_cnt_o, 127);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_known_pair();
        t_clear_priority();
        t_hold();
        for (int n = 0; n < 4; n++) t_frame(7, -1);
        for (int n = 0; n < 4; n++) t_frame(8, -1);
        for (int p = 0; p < 64; p++) t_frame(7, p);
        t_saturate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule